// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a parallel RGB panel. Software writes the total period, the active size and the porch that precedes active video for each axis, plus a fill colour and a control word. From these the block runs two counters and drives horizontal sync, vertical sync, data enable and a pixel-clock enable, each with an individually selectable polarity.

One cycle ahead of the panel outputs it requests pixels from a fetch stage by presenting zero-based column and row coordinates. The colour returned on `pixIn` in that cycle is registered and shown on `rgbOut` together with the matching sync and enable levels. Outside the visible window `rgbOut` carries the fill colour. A one-cycle frame-start pulse fires on the chosen edge of vertical sync, and a wrapping frame counter advances with every pulse.

All settings are held in a staging copy and move into the working copy only at the end of a frame, or on the next cycle while output is disabled, so a frame never mixes two settings.

Top module: `lcd_raster_gen`

## Requirements
- R1: A write with `wrEn` high stores `wrData` at `wrAddr`. Address 0 holds the totals and address 1 the active sizes, with the line count in bits 31-16 and the pixel count in bits 15-0. Addresses 2 (horizontal) and 3 (vertical) hold the porch before active video in bits 15-0; bits 31-16 take the porch after active video, which does not affect timing. Address 4 bits 23-0 hold the fill colour, and address 5 is the control word. Writes to addresses 6 and 7 change nothing.
- R2: Each line lasts the horizontal total in clocks. Horizontal sync is active in the first clock only. The before-active porch follows it, and then come the active pixels.
- R3: Each frame lasts the vertical total in lines. Vertical sync is active for the whole of line 0. The before-active porch lines follow it, and then come the active lines.
- R4: Data enable is active only where an active pixel meets an active line. `pixReq`, `pixX` and `pixY` lead the panel outputs by one clock, and the coordinates start at 0 at the first active pixel and the first active line.
- R5: During data enable, `rgbOut` is the `pixIn` value presented with the matching request. Elsewhere in a running frame it is the fill colour.
- R6: Control bit 1 inverts the pixel-clock enable, bit 2 horizontal sync, bit 3 vertical sync and bit 4 data enable. Without inversion, the pixel-clock enable is high while the panel runs.
- R7: Control bit 0 enables the panel. While it is clear, all four timing outputs and `rgbOut` are 0, no frame start is raised and the counter holds. New settings then apply on the next cycle, and enabling starts the raster at pixel 0 of line 0.
- R8: `frameStart` is a one-clock pulse aligned with the vertical sync edge chosen by control bit 5: 0 selects the start of line 0, and 1 selects the start of line 1.
- R9: `frameCount` rises by one, wrapping, in the same cycle as each `frameStart` pulse, and is otherwise stable.
- R10: Writes made while the panel runs take effect at the first pixel of the next frame.
- R11: After reset all outputs are 0 and the panel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| pixIn | input | 24 | Colour returned by the fetch stage for the current request |
| pixReq | output | 1 | Pixel request, one clock ahead of data enable |
| pixX | output | 16 | Requested column, 0 outside the active window |
| pixY | output | 16 | Requested row, 0 outside the active window |
| hsyncOut | output | 1 | Horizontal sync after polarity |
| vsyncOut | output | 1 | Vertical sync after polarity |
| deOut | output | 1 | Data enable after polarity |
| pclkEnOut | output | 1 | Pixel-clock enable after polarity |
| rgbOut | output | 24 | Pixel colour or fill colour |
| frameStart | output | 1 | Frame-start pulse |
| frameCount | output | 16 | Wrapping frame counter |

## Verification
On every cycle the assertions check four things: the frame-start pulse is one clock wide, the counter steps exactly with it, a disabled panel keeps every output at 0, and data enable and the displayed colour follow the previous cycle's request. Whether syncs, porches and the active window land on the right pixel for a given setting, and whether a mid-frame write is held back until the frame boundary, only the bench's scenarios can show. The bench compares each output on every cycle against a position model, using directed and random settings, inverted polarities and both trigger edges.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  localparam int CW     = 16;      // coordinate / count width
  localparam int DW     = 2 * CW;  // register data width
  localparam int PW     = 24;      // colour width
  localparam int REG_AW = 3;       // register address width

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_PINV = 1;
  localparam int CB_HINV = 2;
  localparam int CB_VINV = 3;
  localparam int CB_DINV = 4;
  localparam int CB_FALL = 5;

  typedef enum logic [REG_AW-1:0] {
    REG_TOTAL  = 3'd0,
    REG_ACTIVE = 3'd1,
    REG_HPORCH = 3'd2,
    REG_VPORCH = 3'd3,
    REG_FILL   = 3'd4,
    REG_CTRL   = 3'd5
  } regSel_t;

  typedef struct packed {
    logic [CW-1:0] hTot;
    logic [CW-1:0] vTot;
    logic [CW-1:0] hAct;
    logic [CW-1:0] vAct;
    logic [CW-1:0] hLead;
    logic [CW-1:0] vLead;
  } rasterTim_t;

  typedef struct packed {
    logic          en;
    logic          pclkInv;
    logic          hsInv;
    logic          vsInv;
    logic          deInv;
    logic          fallEdge;
    logic [PW-1:0] fill;
  } dispCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic hSync;
    logic vSync;
    logic active;
  } rasterStrb_t;
endpackage

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl
  import lcd_raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  output dispCfg_t          curCfg,
  output rasterStrb_t       strb,
  output logic              pixReq,
  output logic [CW-1:0]     pixX,
  output logic [CW-1:0]     pixY
);
  rasterTim_t stgTim, curTim;
  dispCfg_t   stgCfg;
  logic [CW-1:0] hCnt, vCnt;
  logic [CW:0]   hOff, vOff;
  logic hIn, vIn, hLast, vLast, inWin;

  always_comb begin
    hOff  = {1'b0, hCnt} - {1'b0, curTim.hLead} - (CW+1)'(1);
    vOff  = {1'b0, vCnt} - {1'b0, curTim.vLead} - (CW+1)'(1);
    hIn   = (hCnt > curTim.hLead) && (hOff < {1'b0, curTim.hAct});
    vIn   = (vCnt > curTim.vLead) && (vOff < {1'b0, curTim.vAct});
    hLast = ({1'b0, hCnt} + (CW+1)'(1)) >= {1'b0, curTim.hTot};
    vLast = ({1'b0, vCnt} + (CW+1)'(1)) >= {1'b0, curTim.vTot};
    inWin = curCfg.en && hIn && vIn;
  end

  assign strb.run    = curCfg.en;
  assign strb.hSync  = curCfg.en && (hCnt == '0);
  assign strb.vSync  = curCfg.en && (vCnt == '0);
  assign strb.active = inWin;
  assign pixReq      = inWin;
  assign pixX        = inWin ? hOff[CW-1:0] : '0;
  assign pixY        = inWin ? vOff[CW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stgTim <= '0;
      stgCfg <= '0;
      curTim <= '0;
      curCfg <= '0;
      hCnt   <= '0;
      vCnt   <= '0;
    end else begin
      if (wrEn) begin
        case (regSel_t'(wrAddr))
          REG_TOTAL:  begin stgTim.vTot <= wrData[DW-1:CW]; stgTim.hTot <= wrData[CW-1:0]; end
          REG_ACTIVE: begin stgTim.vAct <= wrData[DW-1:CW]; stgTim.hAct <= wrData[CW-1:0]; end
          REG_HPORCH: stgTim.hLead <= wrData[CW-1:0];
          REG_VPORCH: stgTim.vLead <= wrData[CW-1:0];
          REG_FILL:   stgCfg.fill  <= wrData[PW-1:0];
          REG_CTRL: begin
            stgCfg.en       <= wrData[CB_EN];
            stgCfg.pclkInv  <= wrData[CB_PINV];
            stgCfg.hsInv    <= wrData[CB_HINV];
            stgCfg.vsInv    <= wrData[CB_VINV];
            stgCfg.deInv    <= wrData[CB_DINV];
            stgCfg.fallEdge <= wrData[CB_FALL];
          end
          default: ;
        endcase
      end
      if (!curCfg.en) begin
        curTim <= stgTim;
        curCfg <= stgCfg;
        hCnt   <= '0;
        vCnt   <= '0;
      end else if (hLast) begin
        hCnt <= '0;
        if (vLast) begin
          vCnt   <= '0;
          curTim <= stgTim;
          curCfg <= stgCfg;
        end else begin
          vCnt <= vCnt + CW'(1);
        end
      end else begin
        hCnt <= hCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lcd_raster_dp.sv
module lcd_raster_dp
  import lcd_raster_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dispCfg_t      curCfg,
  input  rasterStrb_t   strb,
  input  logic [PW-1:0] pixIn,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic          pclkEnOut,
  output logic [PW-1:0] rgbOut,
  output logic          frameStart,
  output logic [FW-1:0] frameCount
);
  logic vsPrev, startNow;

  always_comb begin
    if (curCfg.fallEdge) startNow = strb.run && vsPrev && !strb.vSync;
    else                 startNow = strb.run && !vsPrev && strb.vSync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsyncOut   <= 1'b0;
      vsyncOut   <= 1'b0;
      deOut      <= 1'b0;
      pclkEnOut  <= 1'b0;
      rgbOut     <= '0;
      vsPrev     <= 1'b0;
      frameStart <= 1'b0;
      frameCount <= '0;
    end else begin
      hsyncOut   <= strb.run && (strb.hSync ^ curCfg.hsInv);
      vsyncOut   <= strb.run && (strb.vSync ^ curCfg.vsInv);
      deOut      <= strb.run && (strb.active ^ curCfg.deInv);
      pclkEnOut  <= strb.run && !curCfg.pclkInv;
      rgbOut     <= !strb.run ? '0 : (strb.active ? pixIn : curCfg.fill);
      vsPrev     <= strb.vSync;
      frameStart <= startNow;
      if (startNow) frameCount <= frameCount + FW'(1);
    end
  end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [PW-1:0]     pixIn,
  output logic              pixReq,
  output logic [CW-1:0]     pixX,
  output logic [CW-1:0]     pixY,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              pclkEnOut,
  output logic [PW-1:0]     rgbOut,
  output logic              frameStart,
  output logic [FW-1:0]     frameCount
);
  dispCfg_t    curCfg;
  rasterStrb_t strb;

  lcd_raster_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .curCfg(curCfg), .strb(strb), .pixReq(pixReq), .pixX(pixX), .pixY(pixY)
  );

  lcd_raster_dp #(.FW(FW)) u_dp (
    .clk(clk), .rst_n(rst_n), .curCfg(curCfg), .strb(strb), .pixIn(pixIn),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pclkEnOut(pclkEnOut),
    .rgbOut(rgbOut), .frameStart(frameStart), .frameCount(frameCount)
  );
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
  parameter int PW = 24,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          runEn,
  input logic          deInv,
  input logic          pixReq,
  input logic [PW-1:0] pixIn,
  input logic [PW-1:0] rgbOut,
  input logic          hsyncOut,
  input logic          vsyncOut,
  input logic          deOut,
  input logic          pclkEnOut,
  input logic          frameStart,
  input logic [FW-1:0] frameCount
);
  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> !frameStart);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> frameCount == $past(frameCount) + FW'(1));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |-> $stable(frameCount));

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(runEn) |-> (rgbOut == '0 && !hsyncOut && !vsyncOut && !deOut
                       && !pclkEnOut && !frameStart));

  // R4
  de_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(runEn) |-> ((deOut ^ $past(deInv)) == $past(pixReq)));

  // R5
  colour_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pixReq) |-> rgbOut == $past(pixIn));
endmodule

bind lcd_raster_gen lcd_raster_chk #(.PW(lcd_raster_pkg::PW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .runEn(curCfg.en), .deInv(curCfg.deInv),
  .pixReq(pixReq), .pixIn(pixIn), .rgbOut(rgbOut), .hsyncOut(hsyncOut),
  .vsyncOut(vsyncOut), .deOut(deOut), .pclkEnOut(pclkEnOut),
  .frameStart(frameStart), .frameCount(frameCount)
);

// File: tb/lcd_raster_gen_test.sv
`timescale 1ns/1ps
module lcd_raster_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [23:0] pixIn;
  logic        pixReq, hsyncOut, vsyncOut, deOut, pclkEnOut, frameStart;
  logic [15:0] pixX, pixY, frameCount;
  logic [23:0] rgbOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "";

  always #10 clk = ~clk;  // 50 MHz

  // fetch stage stand-in: colour encodes the requested coordinates
  assign pixIn = {pixX[7:0], pixY[7:0], 8'hA5};

  lcd_raster_gen uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixIn(pixIn), .pixReq(pixReq), .pixX(pixX), .pixY(pixY),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut), .pclkEnOut(pclkEnOut),
    .rgbOut(rgbOut), .frameStart(frameStart), .frameCount(frameCount)
  );

  typedef struct {
    int hTot; int hAct; int hLead; int hTrail;
    int vTot; int vAct; int vLead; int vTrail;
    bit en; bit pInv; bit hInv; bit vInv; bit dInv; bit fall;
    logic [23:0] fill;
  } mcfg_t;

  mcfg_t cur, pend;
  int mh = 0, mv = 0;
  logic [15:0] expCnt = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (h=%0d v=%0d)", tag, phase, act, exp, mh, mv);
    end
  endtask

  // compare outputs for model position, then advance the model
  task automatic tick();
    bit hs, vs, de, pc, fs, act;
    logic [23:0] rgb;
    int x, y;
    @(negedge clk);
    x = mh - cur.hLead - 1;
    y = mv - cur.vLead - 1;
    act = (mh > cur.hLead) && (x < cur.hAct) && (mv > cur.vLead) && (y < cur.vAct);
    if (!cur.en) begin
      hs = 0; vs = 0; de = 0; pc = 0; fs = 0; rgb = '0;
    end else begin
      hs  = (mh == 0) ^ cur.hInv;
      vs  = (mv == 0) ^ cur.vInv;
      de  = act ^ cur.dInv;
      pc  = !cur.pInv;
      fs  = cur.fall ? (mv == 1 && mh == 0) : (mv == 0 && mh == 0);
      rgb = act ? {x[7:0], y[7:0], 8'hA5} : cur.fill;
    end
    if (fs) expCnt = expCnt + 16'd1;
    chk("R2 hsync", 32'(hsyncOut), 32'(hs));
    chk("R3 vsync", 32'(vsyncOut), 32'(vs));
    chk("R4 data enable", 32'(deOut), 32'(de));
    chk("R6 pixel clock enable", 32'(pclkEnOut), 32'(pc));
    chk("R5 colour", 32'(rgbOut), 32'(rgb));
    chk("R8 frame start", 32'(frameStart), 32'(fs));
    chk("R9 frame count", 32'(frameCount), 32'(expCnt));
    if (!cur.en) begin
      cur = pend; mh = 0; mv = 0;
    end else begin
      mh++;
      if (mh >= cur.hTot) begin
        mh = 0; mv++;
        if (mv >= cur.vTot) begin mv = 0; cur = pend; end
      end
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // R1: register map as stated in the requirement
  task automatic wr(logic [2:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
    case (a)
      3'd0: begin pend.vTot = int'(d[31:16]); pend.hTot = int'(d[15:0]); end
      3'd1: begin pend.vAct = int'(d[31:16]); pend.hAct = int'(d[15:0]); end
      3'd2: pend.hLead = int'(d[15:0]);
      3'd3: pend.vLead = int'(d[15:0]);
      3'd4: pend.fill = d[23:0];
      3'd5: begin
        pend.en = d[0]; pend.pInv = d[1]; pend.hInv = d[2];
        pend.vInv = d[3]; pend.dInv = d[4]; pend.fall = d[5];
      end
      default: ;
    endcase
  endtask

  task automatic wrAll(mcfg_t c);
    wr(3'd0, {16'(c.vTot), 16'(c.hTot)});
    wr(3'd1, {16'(c.vAct), 16'(c.hAct)});
    wr(3'd2, {16'(c.hTrail), 16'(c.hLead)});
    wr(3'd3, {16'(c.vTrail), 16'(c.vLead)});
    wr(3'd4, {8'h00, c.fill});
    wr(3'd5, {26'd0, c.fall, c.dInv, c.vInv, c.hInv, c.pInv, c.en});
  endtask

  function automatic mcfg_t mk(int ha, int hl, int ht, int va, int vl, int vt,
                               bit en, bit inv, bit fall, logic [23:0] fill);
    mcfg_t c;
    c.hAct = ha; c.hLead = hl; c.hTrail = ht; c.hTot = ha + hl + ht + 1;
    c.vAct = va; c.vLead = vl; c.vTrail = vt; c.vTot = va + vl + vt + 1;
    c.en = en; c.pInv = inv; c.hInv = inv; c.vInv = inv; c.dInv = inv;
    c.fall = fall; c.fill = fill;
    return c;
  endfunction

  initial begin
    mcfg_t c;
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    cur = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 24'h0);
    cur.hTot = 0; cur.vTot = 0;
    pend = cur;

    // R11: reset state
    phase = "[R11 reset]";
    repeat (3) @(negedge clk);
    chk("R11 outputs", {hsyncOut, vsyncOut, deOut, pclkEnOut, frameStart, 3'b0, rgbOut},
        32'h0);
    chk("R11 frame count", 32'(frameCount), 32'h0);
    rst_n = 1'b1;
    run(5);

    // R2 R3 R4 R5 R8: plain polarity, rising trigger
    phase = "[directed A]";
    c = mk(6, 2, 3, 4, 1, 2, 1, 0, 0, 24'h123456);
    wrAll(c);
    run(260);

    // R10 R6: mid-frame rewrite with inverted outputs and falling trigger
    phase = "[R10 mid-frame change]";
    run(17);
    c = mk(4, 1, 4, 3, 2, 1, 1, 1, 1, 24'hABCDEF);
    wrAll(c);
    run(260);

    // R1: unmapped addresses change nothing
    phase = "[R1 unmapped write]";
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0001_0001);
    run(120);

    // R7: disable, idle window, re-enable
    phase = "[R7 disable]";
    wr(3'd5, 32'h0);
    run(150);
    phase = "[R7 re-enable]";
    wr(3'd5, 32'h0000_0001);
    run(150);

    // random settings, zero porches allowed
    for (int k = 0; k < 8; k++) begin
      phase = $sformatf("[random %0d]", k);
      c = mk(1 + int'($urandom_range(5)), int'($urandom_range(3)), int'($urandom_range(3)),
             1 + int'($urandom_range(3)), int'($urandom_range(2)), int'($urandom_range(2)),
             1, bit'($urandom_range(1)), bit'($urandom_range(1)), 24'($urandom));
      c.pInv = bit'($urandom_range(1));
      c.hInv = bit'($urandom_range(1));
      wrAll(c);
      run(2 * c.hTot * c.vTot + 2 * 110);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule